// File: doc/BRIEF.md
# Cascaded Two-Stage Watchdog

This block guards a system against a stalled controller with two 16-bit down-counters placed in series. The first counter, the kick stage, must be reloaded regularly, either by a rising edge on an asynchronous hardware trigger pin or by a write to a kick address on the byte-wide register port. If the kicks stop, the kick stage runs out and starts the second counter, the grace stage. Kicks cannot cancel the grace stage. When it also runs out, the block raises an active-high reset pulse that lasts a fixed number of ticks. All counting advances only on a one-cycle `tick` strobe, which comes from a prescaler outside the block.

The reload value of each stage is written one byte at a time. The low byte is held in a staging register. The new 16-bit value takes effect in a single step when the high byte is written, so a counter never sees a half-updated reload value.

The state machine has four states:
- `S_IDLE`: disarmed. Both counters hold their reload values.
- `S_RUN_A`: the kick stage is counting.
- `S_RUN_B`: the grace stage is counting.
- `S_FIRE`: the reset pulse is driven.

The transitions are:
- `arm`: IDLE to RUN_A, on a kick while enabled.
- `expire_a`: RUN_A to RUN_B, on the tick that empties the kick stage.
- `expire_b`: RUN_B to FIRE, on the tick that empties the grace stage.
- `pulse_done`: FIRE to IDLE, on the last tick of the pulse.
- `disable`: any state to IDLE, when `en` is low.

Top module: `cascade_wdog`

## Requirements
- R1: After reset, `wd_reset_o` is low, the state is IDLE, and the reload values are A_INIT (100) and B_INIT (50). With the defaults, an armed watchdog that receives no further kicks asserts reset on tick 150.
- R2: In IDLE the watchdog is disarmed and never asserts reset. It arms (the `arm` transition) only on a kick while `en` is high.
- R3: Once armed with reload values A and B and no further kicks, `wd_reset_o` rises on tick max(A,1)+max(B,1) counted from arming. The kick stage ends on its max(A,1)-th tick, which starts the grace stage.
- R4: A kick during RUN_A reloads the kick stage from its reload value. A kick is either a write of any data to register address 4 or a hardware trigger edge.
- R5: `wd_trig_i` passes through a two-flop synchronizer, and each rising edge counts as exactly one kick. Holding the pin high gives no further kicks.
- R6: Kicks during RUN_B have no effect. Reset still rises on the grace stage's last tick.
- R7: Address 0 writes the low byte of reload A and address 1 writes its high byte. Addresses 2 and 3 do the same for reload B. A low-byte write alone leaves the reload value unchanged. A high-byte write loads {high, staged low} as one 16-bit value.
- R8: `wd_reset_o` stays high for exactly PULSE_TICKS ticks (4 by default). The block then returns to IDLE, disarmed, and needs a new kick to rearm.
- R9: When `en` is low, the next clock edge takes the block to IDLE with `wd_reset_o` low. While `en` stays low, no reset is asserted.
- R10: A reload value of 0 behaves as 1, so that stage lasts one tick.
- R11: When a kick and a tick arrive in the same cycle during RUN_A, the kick wins: the stage reloads and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Watchdog enable |
| tick | input | 1 | One-cycle prescaled count strobe |
| wd_trig_i | input | 1 | Asynchronous hardware kick input, rising edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0/1 reload A low/high, 2/3 reload B low/high, 4 kick |
| reg_wdata | input | 8 | Register write data |
| wd_reset_o | output | 1 | Active-high reset pulse |

## Verification
The bench measures, in ticks, the distance from arming to reset and the width of the pulse. Each corner case is built so that a faulty design gives a different count:
- A level-sensitive trigger would keep reloading the kick stage and never fire.
- A grace stage that accepted kicks would fire late.
- A tick that won over a simultaneous kick would fire one tick early.
- A low-byte write that took effect on its own would shorten the kick stage.
- A zero reload value that wrapped around would stall for about 65536 ticks.

It also checks that the block does not rearm by itself after a pulse, and that dropping the enable during the pulse clears the output on the next edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN_A = 2'd1,
        S_RUN_B = 2'd2,
        S_FIRE  = 2'd3
    } wd_state_e;

    localparam int unsigned WD_NUM_STAGES = 2;
    localparam int unsigned WD_ADDR_KICK  = 4;

endpackage

// File: rtl/wdog_trig_sync.sv
module wdog_trig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wdog_divreg.sv
module wdog_divreg #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned W      = 2 * BYTE_W,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [W-1:0]      div_o
);
    logic [BYTE_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= INIT[BYTE_W-1:0];
            div_o   <= INIT;
        end else begin
            if (we_lo) stage_q <= wdata;
            if (we_hi) div_o   <= {wdata, stage_q};
        end
    end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_o <= RST_VAL;
        else if (load) cnt_o <= load_val;
        else if (dec)  cnt_o <= cnt_o - W'(1);
    end

    assign last_o = (cnt_o <= W'(1));
endmodule

// File: rtl/cascade_wdog.sv
module cascade_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned A_INIT      = 100,
    parameter int unsigned B_INIT      = 50,
    parameter int unsigned PULSE_TICKS = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              wd_trig_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic              wd_reset_o
);
    localparam int unsigned CNT_W = 2 * BYTE_W;
    localparam int unsigned PW    = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] INIT_VALS [WD_NUM_STAGES] =
        '{CNT_W'(A_INIT), CNT_W'(B_INIT)};

    wd_state_e state_q, state_d;

    logic hw_kick, sw_kick, kick_any;
    logic [CNT_W-1:0] div   [WD_NUM_STAGES];
    logic [CNT_W-1:0] cnt   [WD_NUM_STAGES];
    logic             last  [WD_NUM_STAGES];
    logic             load  [WD_NUM_STAGES];
    logic             dec   [WD_NUM_STAGES];
    logic [PW-1:0]    pcnt;
    logic             plast, pload, pdec;

    wdog_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wd_trig_i), .rise_o(hw_kick)
    );

    assign sw_kick  = reg_we && (reg_addr == ADDR_W'(WD_ADDR_KICK));
    assign kick_any = hw_kick | sw_kick;

    for (genvar i = 0; i < WD_NUM_STAGES; i++) begin : g_stage
        logic we_lo, we_hi;
        assign we_lo = reg_we && (reg_addr == ADDR_W'(2 * i));
        assign we_hi = reg_we && (reg_addr == ADDR_W'(2 * i + 1));

        wdog_divreg #(.BYTE_W(BYTE_W), .W(CNT_W), .INIT(INIT_VALS[i])) u_div (
            .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi),
            .wdata(reg_wdata), .div_o(div[i])
        );

        wdog_downcnt #(.W(CNT_W), .RST_VAL(INIT_VALS[i])) u_cnt (
            .clk(clk), .rst_n(rst_n), .load(load[i]), .load_val(div[i]),
            .dec(dec[i]), .cnt_o(cnt[i]), .last_o(last[i])
        );
    end

    wdog_downcnt #(.W(PW), .RST_VAL(PW'(PULSE_TICKS))) u_pulse (
        .clk(clk), .rst_n(rst_n), .load(pload), .load_val(PW'(PULSE_TICKS)),
        .dec(pdec), .cnt_o(pcnt), .last_o(plast)
    );

    // counter controls
    always_comb begin
        load[0] = (state_q != S_RUN_A) || kick_any;
        dec[0]  = (state_q == S_RUN_A) && tick && !kick_any && !last[0];
        load[1] = (state_q != S_RUN_B);
        dec[1]  = (state_q == S_RUN_B) && tick && !last[1];
        pload   = (state_q != S_FIRE);
        pdec    = (state_q == S_FIRE) && tick && !plast;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (en && kick_any) state_d = S_RUN_A;
            S_RUN_A: if (!en) state_d = S_IDLE;
                     else if (tick && !kick_any && last[0]) state_d = S_RUN_B;
            S_RUN_B: if (!en) state_d = S_IDLE;
                     else if (tick && last[1]) state_d = S_FIRE;
            S_FIRE:  if (!en) state_d = S_IDLE;
                     else if (tick && plast) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wd_reset_o = (state_q == S_FIRE);
    end

    logic unused_cnt;
    assign unused_cnt = ^{cnt[0], cnt[1], pcnt};
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      en,
    input logic      tick,
    input logic      kick,
    input wd_state_e state,
    input logic      wd_reset_o
);
    // R2: stays disarmed without an enabled kick
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !(en && kick)) |=> (state == S_IDLE));

    // R3: kick stage only hands over on a tick
    a_r3_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN_A && !tick) |=> (state != S_RUN_B));

    // R6: grace stage is not left without a tick while enabled
    a_r6_grace_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN_B && en && !tick) |=> (state == S_RUN_B));

    // R8: pulse begins only out of the grace stage
    a_r8_pulse_from_grace: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_o) |-> $past(state == S_RUN_B));

    // R8: pulse ends in the disarmed state
    a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_reset_o) |-> (state == S_IDLE));

    // R9: disable clears the output on the next edge
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wd_reset_o);
endmodule

bind cascade_wdog wdog_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .kick(kick_any),
    .state(state_q), .wd_reset_o(wd_reset_o)
);

// File: tb/tb_cascade_wdog.sv
module tb_cascade_wdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       wd_trig_i = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       wd_reset_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cascade_wdog dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wd_trig_i(wd_trig_i),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wd_reset_o(wd_reset_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(addr); reg_wdata = 8'(data);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic sw_kick();
        wr(4, 8'h5a);
    endtask

    task automatic set_div(input int idx, input int val);
        wr(2 * idx, val & 8'hff);
        wr(2 * idx + 1, (val >> 8) & 8'hff);
    endtask

    task automatic hw_rise();
        @(negedge clk) wd_trig_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic hw_fall();
        @(negedge clk) wd_trig_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks_to_reset(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            tick_once();
            n++;
            if (wd_reset_o) break;
        end
        if (!wd_reset_o) n = -1;
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        for (int i = 0; i < 64; i++) begin
            tick_once();
            n++;
            if (!wd_reset_o) break;
        end
    endtask

    task automatic quiet_ticks(input int cnt, output int seen);
        seen = 0;
        for (int i = 0; i < cnt; i++) begin
            tick_once();
            if (wd_reset_o) seen++;
        end
    endtask

    task automatic t_reset_and_defaults();
        int n;
        check("R1 reset output", int'(wd_reset_o), 0);
        en = 1'b1;
        quiet_ticks(20, n);
        check("R2 no fire while disarmed", n, 0);
        sw_kick();
        ticks_to_reset(400, n);
        check("R1 default timeout ticks", n, 150);
        pulse_len(n);
        check("R8 pulse length", n, 4);
        quiet_ticks(30, n);
        check("R8 stays disarmed after pulse", n, 0);
    endtask

    task automatic t_programmed();
        int n;
        set_div(0, 5);
        set_div(1, 3);
        sw_kick();
        ticks_to_reset(400, n);
        check("R3 A+B ticks", n, 8);
        pulse_len(n);
        check("R8 pulse length again", n, 4);
    endtask

    task automatic t_sw_reload();
        int n;
        sw_kick();
        repeat (4) tick_once();
        sw_kick();
        ticks_to_reset(400, n);
        check("R4 software kick reloads", n, 8);
        pulse_len(n);
    endtask

    task automatic t_hw_trigger();
        int n;
        hw_rise();
        repeat (4) tick_once();
        ticks_to_reset(400, n);
        check("R5 held trigger is one kick", n, 4);
        hw_fall();
        pulse_len(n);
        hw_rise();
        hw_fall();
        repeat (3) tick_once();
        hw_rise();
        hw_fall();
        ticks_to_reset(400, n);
        check("R4 hardware kick reloads", n, 8);
        pulse_len(n);
    endtask

    task automatic t_grace_ignores_kick();
        int n;
        sw_kick();
        repeat (5) tick_once();
        sw_kick();
        hw_rise();
        hw_fall();
        ticks_to_reset(400, n);
        check("R6 kicks ignored in grace stage", n, 3);
        pulse_len(n);
    endtask

    task automatic t_kick_beats_tick();
        int n;
        sw_kick();
        repeat (4) tick_once();
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        ticks_to_reset(400, n);
        check("R11 kick wins over tick", n, 8);
        pulse_len(n);
    endtask

    task automatic t_disable();
        int n;
        sw_kick();
        repeat (6) tick_once();
        @(negedge clk) en = 1'b0;
        quiet_ticks(20, n);
        check("R9 no fire while disabled", n, 0);
        @(negedge clk) en = 1'b1;
        quiet_ticks(20, n);
        check("R9 re-enable stays idle", n, 0);
        sw_kick();
        ticks_to_reset(400, n);
        check("R9 rearm after enable", n, 8);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        check("R9 disable drops pulse", int'(wd_reset_o), 0);
        @(negedge clk) en = 1'b1;
    endtask

    task automatic t_atomic_write();
        int n;
        wr(0, 2);
        sw_kick();
        ticks_to_reset(400, n);
        check("R7 low byte alone no effect", n, 8);
        pulse_len(n);
        wr(1, 0);
        sw_kick();
        ticks_to_reset(400, n);
        check("R7 high byte commits value", n, 5);
        pulse_len(n);
    endtask

    task automatic t_zero_div();
        int n;
        set_div(0, 0);
        sw_kick();
        ticks_to_reset(400, n);
        check("R10 zero reload acts as one", n, 4);
        pulse_len(n);
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_defaults();
        t_programmed();
        t_sw_reload();
        t_hw_trigger();
        t_grace_ignores_kick();
        t_kick_beats_tick();
        t_disable();
        t_atomic_write();
        t_zero_div();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule